// File: doc/BRIEF.md
# Panel Self-Refresh State Controller

This block sits beside a display pipe and decides when the attached panel may refresh itself from its own frame store, so that the pipe can stop fetching from memory. A single configuration word holds an enable bit, a three-bit policy field and a self-clearing resynchronise bit. Two strobes come from the pipe. One marks each frame. The other marks any register write that could alter the frame buffer. Two pulse inputs carry software commands to enter or leave self-refresh.

The controller has four states. OFF is inactive. IDLE is armed, with frames still fetched from memory. CG is active with clocks gated. PG is active with power gated. Three policies are available. In the hardware idle-timer policy, the block enters self-refresh on its own after a number of quiet frames, and any frame-buffer write pulls it back out. In the software-timer policy, entry and exit follow commands only, and the gated-to-power-gated step happens automatically. In the manual policy, every step is a command.

Status outputs give the current state, the state before the last change, a one-cycle transition flag, a standby code and a saturating count of repeated frames.

Top module: `psr_ctrl`

## Requirements
- R1: Synchronous reset clears every output: `cur_state` is 0 (OFF), `last_state` is 0, `in_transition` is 0, `rpt_count` is 0, `standby` is 0 and `cfg_rdata` is 0.
- R2: The configuration word is laid out as bit 0 = enable, bit 1 = resynchronise, bits 4:2 = policy. Policy code 3'b010 is hardware timer, 3'b001 is software timer and 3'b000 is manual. While enable is 0, or the policy is one of the codes 3'b011 to 3'b111, the state goes to OFF (0) on the next edge and stays there. From OFF, with a valid enabled policy, the state moves to IDLE (1) on the next edge.
- R3: In hardware-timer policy, the state moves from IDLE to CG (2) on the edge of the IDLE_FRAMES-th frame strobe that has no frame-buffer write in between. The default for IDLE_FRAMES is 2. A frame-buffer write restarts the count.
- R4: In hardware-timer policy, a frame-buffer write while in CG or PG returns the state to IDLE on that edge.
- R5: In software-timer policy, the block enters CG only on `sw_enter` while in IDLE, and leaves to IDLE only on `sw_exit` while in CG or PG. Frame strobes and frame-buffer writes never cause entry or exit in this policy.
- R6: In hardware-timer and software-timer policies, CG moves to PG (3) on the DEEP_FRAMES-th frame strobe spent in CG. The default for DEEP_FRAMES is 4.
- R7: In manual policy, `sw_enter` steps the state from IDLE to CG and from CG to PG, and `sw_exit` returns it from CG or PG to IDLE. No other transition occurs.
- R8: Writing the word with bit 1 set sends the state to OFF on that edge and clears `rpt_count`. The other fields of the word are stored, and bit 1 always reads back as 0 on `cfg_rdata`.
- R9: `in_transition` is high for exactly the one cycle after each state change. `last_state` then holds the state that was left.
- R10: `rpt_count` adds 1 for each frame strobe that arrives while the block is in CG or PG and stays there. The count stops at 255 without wrapping, and it returns to 0 on the edge that leaves CG or PG.
- R11: `standby` is 2'b00 in OFF and IDLE, 2'b10 in CG and 2'b11 in PG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 5 | Configuration word: [0] enable, [1] resynchronise, [4:2] policy |
| cfg_rdata | output | 5 | Stored configuration word; bit 1 always 0 |
| frame_tick | input | 1 | One-cycle strobe per frame |
| fb_write | input | 1 | Strobe for a write that may change the frame buffer |
| sw_enter | input | 1 | Software command to enter or deepen self-refresh |
| sw_exit | input | 1 | Software command to leave self-refresh |
| cur_state | output | 2 | Current state: 0 OFF, 1 IDLE, 2 CG, 3 PG |
| last_state | output | 2 | State held before the most recent change |
| in_transition | output | 1 | High for one cycle after each state change |
| rpt_count | output | 8 | Saturating count of repeated frames while active |
| standby | output | 2 | Local standby code |

## Verification
The assertions assume that each strobe and command lasts one cycle. They also assume that software never raises `sw_enter` and `sw_exit` together, so that each command names a single intended step. The stimulus drives every input for exactly one cycle and then returns it to zero, and it never combines the two commands. Where a frame strobe and a frame-buffer write would overlap, the stimulus gives them separate cycles, so each expected state follows from a single rule.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int CFG_W     = 5;
    localparam int EN_BIT    = 0;
    localparam int RESYNC_BIT = 1;
    localparam int MODE_LSB  = 2;
    localparam int MODE_W    = 3;

    localparam logic [MODE_W-1:0] MODE_MANUAL = 3'b000;
    localparam logic [MODE_W-1:0] MODE_SWTMR  = 3'b001;
    localparam logic [MODE_W-1:0] MODE_HWTMR  = 3'b010;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_IDLE = 2'b01,
        ST_CG   = 2'b10,
        ST_PG   = 2'b11
    } psr_state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              en;
    } psr_cfg_t;

    function automatic logic mode_ok(input logic [MODE_W-1:0] m);
        return (m == MODE_MANUAL) || (m == MODE_SWTMR) || (m == MODE_HWTMR);
    endfunction

    function automatic logic is_active(input psr_state_e s);
        return (s == ST_CG) || (s == ST_PG);
    endfunction

    function automatic logic [1:0] standby_code(input psr_state_e s);
        case (s)
            ST_CG:   return 2'b10;
            ST_PG:   return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/psr_cfg.sv
module psr_cfg
    import psr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output psr_cfg_t         cfg,
    output logic             resync,
    output logic [CFG_W-1:0] rdata
);

    psr_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q.mode <= wdata[MODE_LSB +: MODE_W];
            cfg_q.en   <= wdata[EN_BIT];
        end
    end

    // Resynchronise acts in the write cycle and is never stored.
    assign resync = wr & wdata[RESYNC_BIT];
    assign cfg    = cfg_q;
    assign rdata  = {cfg_q.mode, 1'b0, cfg_q.en};

    // R8: a written word is visible on the next cycle with bit 1 clear
    a_r8_word_loaded: assert property (@(posedge clk) disable iff (rst)
        wr |=> (rdata == {$past(wdata[MODE_LSB +: MODE_W]), 1'b0, $past(wdata[EN_BIT])}));

endmodule

// File: rtl/psr_fsm.sv
module psr_fsm
    import psr_pkg::*;
#(
    parameter int IDLE_FRAMES = 2,
    parameter int DEEP_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  psr_cfg_t   cfg,
    input  logic       resync,
    input  logic       frame_tick,
    input  logic       fb_write,
    input  logic       sw_enter,
    input  logic       sw_exit,
    output psr_state_e state,
    output psr_state_e state_nxt,
    output psr_state_e last_state,
    output logic       in_transition
);

    localparam int IW = $clog2(IDLE_FRAMES + 1);
    localparam int DW = $clog2(DEEP_FRAMES + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_FRAMES - 1);
    localparam logic [DW-1:0] DEEP_LAST = DW'(DEEP_FRAMES - 1);

    psr_state_e    st_q, st_n, last_q;
    logic [IW-1:0] idle_q, idle_n;
    logic [DW-1:0] deep_q, deep_n;
    logic          trans_q;
    logic          hw, man;

    assign hw  = (cfg.mode == MODE_HWTMR);
    assign man = (cfg.mode == MODE_MANUAL);

    always_comb begin
        st_n   = st_q;
        idle_n = idle_q;
        deep_n = deep_q;
        if (resync || !cfg.en || !mode_ok(cfg.mode)) begin
            st_n   = ST_OFF;
            idle_n = '0;
            deep_n = '0;
        end else begin
            case (st_q)
                ST_OFF: begin
                    st_n   = ST_IDLE;
                    idle_n = '0;
                    deep_n = '0;
                end
                ST_IDLE: begin
                    deep_n = '0;
                    if (hw) begin
                        if (fb_write) begin
                            idle_n = '0;
                        end else if (frame_tick) begin
                            if (idle_q == IDLE_LAST) begin
                                st_n   = ST_CG;
                                idle_n = '0;
                            end else begin
                                idle_n = idle_q + 1'b1;
                            end
                        end
                    end else if (sw_enter) begin
                        st_n = ST_CG;
                    end
                end
                ST_CG: begin
                    idle_n = '0;
                    if (hw && fb_write) begin
                        st_n   = ST_IDLE;
                        deep_n = '0;
                    end else if (!hw && sw_exit) begin
                        st_n   = ST_IDLE;
                        deep_n = '0;
                    end else if (man) begin
                        if (sw_enter) st_n = ST_PG;
                    end else if (frame_tick) begin
                        if (deep_q == DEEP_LAST) begin
                            st_n   = ST_PG;
                            deep_n = '0;
                        end else begin
                            deep_n = deep_q + 1'b1;
                        end
                    end
                end
                default: begin
                    idle_n = '0;
                    deep_n = '0;
                    if ((hw && fb_write) || (!hw && sw_exit)) st_n = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OFF;
            last_q  <= ST_OFF;
            idle_q  <= '0;
            deep_q  <= '0;
            trans_q <= 1'b0;
        end else begin
            st_q    <= st_n;
            idle_q  <= idle_n;
            deep_q  <= deep_n;
            trans_q <= (st_n != st_q);
            if (st_n != st_q) last_q <= st_q;
        end
    end

    assign state         = st_q;
    assign state_nxt     = st_n;
    assign last_state    = last_q;
    assign in_transition = trans_q;

    // R2: disabled controller is inactive on the next cycle
    a_r2_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> (state == ST_OFF));

    // R8: resynchronise forces the inactive state
    a_r8_resync_off: assert property (@(posedge clk) disable iff (rst)
        resync |=> (state == ST_OFF));

    // R4: frame-buffer write leaves self-refresh in hardware policy
    a_r4_fb_exit: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && hw && !resync && fb_write && is_active(state)) |=> (state == ST_IDLE));

    // R5: software policy stays armed without an enter command
    a_r5_sw_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && cfg.mode == MODE_SWTMR && !resync && state == ST_IDLE && !sw_enter)
        |=> (state == ST_IDLE));

    // R7: manual policy makes no move without a command
    a_r7_manual_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && man && !resync && !sw_enter && !sw_exit && state != ST_OFF)
        |=> $stable(state));

    // R9: transition flag marks a real change and records the old state
    a_r9_flag_change: assert property (@(posedge clk) disable iff (rst)
        in_transition |-> (state != $past(state)));
    a_r9_last_kept: assert property (@(posedge clk) disable iff (rst)
        in_transition |-> (last_state == $past(state)));

endmodule

// File: rtl/psr_rpt_cnt.sv
module psr_rpt_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             act_now,
    input  logic             act_next,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !act_next) begin
            cnt_q <= '0;
        end else if (tick && act_now && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

    // R10: the count holds at its maximum
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && act_next) |=> (cnt_q == CNT_MAX));

    // R10: nothing is counted outside self-refresh
    a_r10_zero_inactive: assert property (@(posedge clk) disable iff (rst)
        !act_now |-> (cnt_q == '0));

endmodule

// File: rtl/psr_ctrl.sv
module psr_ctrl
    import psr_pkg::*;
#(
    parameter int IDLE_FRAMES = 2,
    parameter int DEEP_FRAMES = 4,
    parameter int RPT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [4:0]       cfg_wdata,
    output logic [4:0]       cfg_rdata,
    input  logic             frame_tick,
    input  logic             fb_write,
    input  logic             sw_enter,
    input  logic             sw_exit,
    output logic [1:0]       cur_state,
    output logic [1:0]       last_state,
    output logic             in_transition,
    output logic [RPT_W-1:0] rpt_count,
    output logic [1:0]       standby
);

    psr_cfg_t   cfg;
    logic       resync;
    psr_state_e st, st_nxt, st_last;

    psr_cfg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .resync(resync),
        .rdata (cfg_rdata)
    );

    psr_fsm #(
        .IDLE_FRAMES(IDLE_FRAMES),
        .DEEP_FRAMES(DEEP_FRAMES)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .resync       (resync),
        .frame_tick   (frame_tick),
        .fb_write     (fb_write),
        .sw_enter     (sw_enter),
        .sw_exit      (sw_exit),
        .state        (st),
        .state_nxt    (st_nxt),
        .last_state   (st_last),
        .in_transition(in_transition)
    );

    psr_rpt_cnt #(
        .CNT_W(RPT_W)
    ) u_rpt (
        .clk     (clk),
        .rst     (rst),
        .tick    (frame_tick),
        .act_now (is_active(st)),
        .act_next(is_active(st_nxt)),
        .count   (rpt_count)
    );

    assign cur_state  = st;
    assign last_state = st_last;
    assign standby    = standby_code(st);

    // R11: an active state always reports a gated standby code
    a_r11_gated_code: assert property (@(posedge clk) disable iff (rst)
        (cur_state[1] == 1'b1) |-> (standby[1] == 1'b1 && standby[0] == cur_state[0]));

endmodule

// File: tb/psr_ctrl_bench.sv
module psr_ctrl_bench;

    typedef struct packed {
        logic       wr;
        logic [4:0] wd;
        logic       frm;
        logic       fbw;
        logic       ent;
        logic       ext;
        logic [1:0] st;
        logic [1:0] sb;
        logic [7:0] rpt;
        logic       tr;
    } vec_t;

    localparam int NV = 34;
    // Columns: wr wdata frame fbwrite enter exit | state standby rpt transition
    localparam vec_t VEC [NV] = '{
        '{1'b1, 5'h09, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 8'd0, 1'b0}, // 0  R2 hw policy written
        '{1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b1}, // 1  R2 arms
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b0}, // 2  R3 quiet frame 1
        '{1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b0}, // 3  R3 write restarts
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b0}, // 4  R3 quiet frame 1
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'b10, 8'd0, 1'b1}, // 5  R3 enters CG
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'b10, 8'd1, 1'b0}, // 6  R10
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'b10, 8'd2, 1'b0}, // 7  R10
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'b10, 8'd3, 1'b0}, // 8  R6
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'b11, 8'd4, 1'b1}, // 9  R6 deepens
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'b11, 8'd5, 1'b0}, // 10 R11
        '{1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b1}, // 11 R4 exit, R10 clear
        '{1'b1, 5'h05, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b0}, // 12 R5 sw policy
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b0}, // 13 R5 no auto entry
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b0}, // 14 R5
        '{1'b0, 5'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'b10, 8'd0, 1'b1}, // 15 R5 enter
        '{1'b0, 5'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'b10, 8'd0, 1'b0}, // 16 R5 write ignored
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'b10, 8'd1, 1'b0}, // 17 R10
        '{1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'b00, 8'd0, 1'b1}, // 18 R5 exit
        '{1'b1, 5'h01, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b0}, // 19 R7 manual policy
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b0}, // 20 R7 no auto
        '{1'b0, 5'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'b10, 8'd0, 1'b1}, // 21 R7 enter
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'b10, 8'd1, 1'b0}, // 22 R7
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'b10, 8'd2, 1'b0}, // 23 R7
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'b10, 8'd3, 1'b0}, // 24 R7
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'b10, 8'd4, 1'b0}, // 25 R7 no auto deepen
        '{1'b0, 5'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 2'b11, 8'd4, 1'b1}, // 26 R7 deepen
        '{1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'b00, 8'd0, 1'b1}, // 27 R7 exit
        '{1'b1, 5'h0B, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 8'd0, 1'b1}, // 28 R8 resync
        '{1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b1}, // 29 R8 rearms
        '{1'b1, 5'h1D, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'b00, 8'd0, 1'b0}, // 30 R2 reserved code
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 8'd0, 1'b1}, // 31 R2 off
        '{1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 8'd0, 1'b0}, // 32 R2
        '{1'b1, 5'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'b00, 8'd0, 1'b0}  // 33 R2 disabled
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       frame_tick = 1'b0;
    logic       fb_write = 1'b0;
    logic       sw_enter = 1'b0;
    logic       sw_exit = 1'b0;
    logic [4:0] cfg_rdata;
    logic [1:0] cur_state, last_state, standby;
    logic       in_transition;
    logic [7:0] rpt_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psr_ctrl u_psr_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .frame_tick   (frame_tick),
        .fb_write     (fb_write),
        .sw_enter     (sw_enter),
        .sw_exit      (sw_exit),
        .cur_state    (cur_state),
        .last_state   (last_state),
        .in_transition(in_transition),
        .rpt_count    (rpt_count),
        .standby      (standby)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [4:0] wd, input logic frm,
                        input logic fbw, input logic ent, input logic ext);
        @(negedge clk);
        cfg_wr = wr; cfg_wdata = wd; frame_tick = frm;
        fb_write = fbw; sw_enter = ent; sw_exit = ext;
        @(posedge clk);
        #2;
        cfg_wr = 1'b0; cfg_wdata = '0; frame_tick = 1'b0;
        fb_write = 1'b0; sw_enter = 1'b0; sw_exit = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R1 reset state
        check("R1 state", cur_state, 0);
        check("R1 last", last_state, 0);
        check("R1 trans", in_transition, 0);
        check("R1 rpt", rpt_count, 0);
        check("R1 standby", standby, 0);
        check("R1 rdata", cfg_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, VEC[i].wd, VEC[i].frm, VEC[i].fbw, VEC[i].ent, VEC[i].ext);
            check($sformatf("vec%0d state (R2..R8)", i), cur_state, VEC[i].st);
            check($sformatf("vec%0d standby R11", i), standby, VEC[i].sb);
            check($sformatf("vec%0d count R10", i), rpt_count, VEC[i].rpt);
            check($sformatf("vec%0d flag R9", i), in_transition, VEC[i].tr);
        end
        check("R9 last after reserved exit", last_state, 1);

        // R10 saturation under software policy, then R8 resync while active
        step(1'b1, 5'h05, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 5'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R5 entered", cur_state, 2);
        for (int k = 0; k < 260; k++) step(1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R10 saturated", rpt_count, 255);
        check("R6 deep", cur_state, 3);
        step(1'b1, 5'h07, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 state off", cur_state, 0);
        check("R8 count cleared", rpt_count, 0);
        check("R8 readback", cfg_rdata, 5'h05);
        check("R9 last was PG", last_state, 3);

        // R1 reset during activity
        step(1'b0, 5'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 5'h00, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b0, 5'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R10 counting", rpt_count, 2);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        rst = 1'b0;
        check("R1 state after reset", cur_state, 0);
        check("R1 count after reset", rpt_count, 0);
        check("R1 rdata after reset", cfg_rdata, 0);
        check("R1 last after reset", last_state, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule